// File: doc/BRIEF.md
# Interrupt Clear Ports with Service-Latency Statistics

This block holds the three interrupt status registers of a storage-bus host adapter: two registers for bus events and one for host-side events. Each register has its own write-only clear port. A host write to a clear port drops every status bit that is set in the written data and leaves the other bits alone. The logic that raises interrupts is outside the block. It drives per-bit set vectors, which the block ORs into the status registers.

The block also measures how long the host took to service each interrupt. There are three latency classes:

- the bus class, which is closed by a write to either bus clear port;
- the sequencer class, which is closed by a write to the host clear port;
- the command-complete class, which is also closed by a write to the host clear port.

A start pulse for a class records the current value of a free-running time counter and arms that class. The first clear write that follows closes the measurement. The elapsed time is added to a saturating sum, folded into a running minimum and maximum, and counted. The class is then disarmed, so later clears leave its statistics unchanged until the next start pulse.

All statistics are flat output vectors, with class 0 in the lowest slice, class 1 next and class 2 highest.

Top module: `irq_clear_stats`

## Requirements
- R1: A write to a clear port updates its status register to old & ~data. The clear addresses are 0 for bus register A, 1 for bus register B and 2 for the host register. The other two status registers keep their values.
- R2: A set vector ORs its bits into its status register. When a bit is set and cleared in the same cycle, it ends up set.
- R3: A write to any address other than 0, 1 or 2 changes no status bit and no statistic.
- R4: On the first clear of an armed class, the latency is time_now minus the captured start time, modulo 2^TW. It is added to the sum, compared into the minimum and the maximum, and the sample count rises by one. All of these are visible one cycle after the write.
- R5: While a class is disarmed, clear writes leave its sum, minimum, maximum and count unchanged.
- R6: A write to address 2 closes both class 1 (sequencer) and class 2 (command-complete) in the same cycle, each only if armed. Writes to address 0 or 1 close class 0 (bus).
- R7: A start pulse captures time_now and arms its class. When a start pulse and a clear for the same class arrive in the same cycle, the start wins and no sample is taken.
- R8: After reset, all status bits are zero, every minimum is all-ones, every maximum, sum and count is zero, and all classes are disarmed.
- R9: The sum saturates at all-ones instead of wrapping. The sample count also saturates at all-ones.
- R10: A clear write with all-zero data still takes a latency sample for an armed class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; on a clear port, a mask of the bits to drop |
| time_now | input | TW | Free-running time counter |
| set_bus0 | input | DW | Set bits for bus status register A |
| set_bus1 | input | DW | Set bits for bus status register B |
| set_host | input | DW | Set bits for host status register |
| start | input | 3 | Per-class interrupt-start pulses (bit 0 bus, bit 1 sequencer, bit 2 command-complete) |
| stat_bus0 | output | DW | Bus status register A |
| stat_bus1 | output | DW | Bus status register B |
| stat_host | output | DW | Host status register |
| lat_sum | output | 3*SW | Per-class saturating latency sum |
| lat_min | output | 3*TW | Per-class minimum latency |
| lat_max | output | 3*TW | Per-class maximum latency |
| lat_cnt | output | 3*CW | Per-class saturating sample count |

## Verification
Every result in this block comes from a single register stage. A status change, a latency sample or a re-arm is therefore visible exactly one rising edge after the edge that samples the write, set or start. The bench drives inputs on falling edges, so they are stable across the rising edge. A behavioural model updates at the same rising edge, and every output is compared against that model on the following falling edge, so each comparison lands on the first cycle in which the result is due.

// File: rtl/irq_clear_stats.sv
module irq_clear_stats #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int TW = 32,
  parameter int SW = 32,
  parameter int CW = 16,
  parameter logic [AW-1:0] A_CLR_BUS0 = 0,
  parameter logic [AW-1:0] A_CLR_BUS1 = 1,
  parameter logic [AW-1:0] A_CLR_HOST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [TW-1:0]   time_now,
  input  logic [DW-1:0]   set_bus0,
  input  logic [DW-1:0]   set_bus1,
  input  logic [DW-1:0]   set_host,
  input  logic [2:0]      start,
  output logic [DW-1:0]   stat_bus0,
  output logic [DW-1:0]   stat_bus1,
  output logic [DW-1:0]   stat_host,
  output logic [3*SW-1:0] lat_sum,
  output logic [3*TW-1:0] lat_min,
  output logic [3*TW-1:0] lat_max,
  output logic [3*CW-1:0] lat_cnt
);
  localparam int NC  = 3;
  localparam int EXT = SW + 1 - TW;

  logic hit_b0, hit_b1, hit_h;
  logic [NC-1:0] cls_hit;

  assign hit_b0  = wr_en && (wr_addr == A_CLR_BUS0);
  assign hit_b1  = wr_en && (wr_addr == A_CLR_BUS1);
  assign hit_h   = wr_en && (wr_addr == A_CLR_HOST);
  assign cls_hit = {hit_h, hit_h, hit_b0 | hit_b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_bus0 <= '0;
      stat_bus1 <= '0;
      stat_host <= '0;
    end else begin
      stat_bus0 <= (stat_bus0 & ~(hit_b0 ? wr_data : '0)) | set_bus0;
      stat_bus1 <= (stat_bus1 & ~(hit_b1 ? wr_data : '0)) | set_bus1;
      stat_host <= (stat_host & ~(hit_h  ? wr_data : '0)) | set_host;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cls
    logic [TW-1:0] ts, lat, mn, mx;
    logic [SW-1:0] sum;
    logic [SW:0]   sum_nx;
    logic [CW-1:0] cnt;
    logic          done, take;

    assign lat    = time_now - ts;
    assign take   = cls_hit[c] && !done && !start[c];
    assign sum_nx = {1'b0, sum} + {{EXT{1'b0}}, lat};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ts   <= '0;
        done <= 1'b1;
        sum  <= '0;
        mn   <= '1;
        mx   <= '0;
        cnt  <= '0;
      end else if (start[c]) begin
        ts   <= time_now;
        done <= 1'b0;
      end else if (take) begin
        done <= 1'b1;
        sum  <= sum_nx[SW] ? '1 : sum_nx[SW-1:0];
        if (lat < mn) mn <= lat;
        if (lat > mx) mx <= lat;
        if (!(&cnt)) cnt <= cnt + 1'b1;
      end
    end

    assign lat_sum[c*SW +: SW] = sum;
    assign lat_min[c*TW +: TW] = mn;
    assign lat_max[c*TW +: TW] = mx;
    assign lat_cnt[c*CW +: CW] = cnt;
  end
endmodule

module irq_clear_stats_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int TW = 32,
  parameter int SW = 32,
  parameter int CW = 16,
  parameter logic [AW-1:0] A_CLR_BUS0 = 0,
  parameter logic [AW-1:0] A_CLR_BUS1 = 1,
  parameter logic [AW-1:0] A_CLR_HOST = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] set_bus0,
  input logic [DW-1:0] set_bus1,
  input logic [DW-1:0] set_host,
  input logic [2:0]    start,
  input logic [DW-1:0] stat_bus0,
  input logic [DW-1:0] stat_bus1,
  input logic [DW-1:0] stat_host,
  input logic [SW-1:0] sum0,
  input logic [TW-1:0] min0,
  input logic [TW-1:0] max0,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  logic other_addr;
  assign other_addr = wr_en && (wr_addr != A_CLR_BUS0) && (wr_addr != A_CLR_BUS1)
                      && (wr_addr != A_CLR_HOST);

  assert_clear_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR_BUS1 && set_bus1 == '0)
    |=> stat_bus1 == ($past(stat_bus1) & ~$past(wr_data)));

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_host != '0) |=> ((stat_host & $past(set_host)) == $past(set_host)));

  assert_other_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (other_addr && set_bus0 == '0) |=> $stable(stat_bus0));

  assert_min_le_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 != '0) |-> (min0 <= max0));

  assert_no_clear_no_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == A_CLR_BUS0 || wr_addr == A_CLR_BUS1)) |=> $stable(cnt0));

  assert_start_no_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start[1] |=> $stable(cnt1));

  assert_sum_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sum0 >= $past(sum0)));
endmodule

bind irq_clear_stats irq_clear_stats_chk #(
  .AW(AW), .DW(DW), .TW(TW), .SW(SW), .CW(CW),
  .A_CLR_BUS0(A_CLR_BUS0), .A_CLR_BUS1(A_CLR_BUS1), .A_CLR_HOST(A_CLR_HOST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .set_bus0(set_bus0), .set_bus1(set_bus1), .set_host(set_host), .start(start),
  .stat_bus0(stat_bus0), .stat_bus1(stat_bus1), .stat_host(stat_host),
  .sum0(lat_sum[SW-1:0]), .min0(lat_min[TW-1:0]), .max0(lat_max[TW-1:0]),
  .cnt0(lat_cnt[CW-1:0]), .cnt1(lat_cnt[2*CW-1:CW])
);

// File: tb/tb_irq_clear_stats.sv
`timescale 1ns/1ps
module tb_irq_clear_stats;
  localparam int AW = 4, DW = 8, TW = 32, SW = 32, CW = 4;
  localparam longint TMASK = (64'd1 << TW) - 1;
  localparam longint SMAX  = (64'd1 << SW) - 1;
  localparam longint CMAX  = (64'd1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0, set_bus0 = '0, set_bus1 = '0, set_host = '0;
  logic [TW-1:0] time_now = '0;
  logic [2:0] start = '0;
  logic [DW-1:0] stat_bus0, stat_bus1, stat_host;
  logic [3*SW-1:0] lat_sum;
  logic [3*TW-1:0] lat_min, lat_max;
  logic [3*CW-1:0] lat_cnt;

  irq_clear_stats #(.AW(AW), .DW(DW), .TW(TW), .SW(SW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .time_now(time_now), .set_bus0(set_bus0), .set_bus1(set_bus1), .set_host(set_host),
    .start(start), .stat_bus0(stat_bus0), .stat_bus1(stat_bus1), .stat_host(stat_host),
    .lat_sum(lat_sum), .lat_min(lat_min), .lat_max(lat_max), .lat_cnt(lat_cnt));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  string req = "R8";

  logic [DW-1:0] m_st [3];
  longint m_ts [3], m_sum [3], m_min [3], m_max [3], m_cnt [3];
  bit m_done [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_st[c] = '0; m_ts[c] = 0; m_sum[c] = 0; m_min[c] = TMASK;
        m_max[c] = 0; m_cnt[c] = 0; m_done[c] = 1;
      end
    end else begin
      bit h [3];
      h[0] = wr_en && (wr_addr == 0 || wr_addr == 1);
      h[1] = wr_en && wr_addr == 2;
      h[2] = h[1];
      for (int c = 0; c < 3; c++) begin
        if (start[c]) begin
          m_ts[c] = time_now; m_done[c] = 0;
        end else if (h[c] && !m_done[c]) begin
          longint l;
          l = (longint'(time_now) - m_ts[c]) & TMASK;
          m_done[c] = 1;
          m_sum[c] = (m_sum[c] + l > SMAX) ? SMAX : m_sum[c] + l;
          if (l < m_min[c]) m_min[c] = l;
          if (l > m_max[c]) m_max[c] = l;
          if (m_cnt[c] < CMAX) m_cnt[c]++;
        end
      end
      m_st[0] = (m_st[0] & ~((wr_en && wr_addr == 0) ? wr_data : 8'h0)) | set_bus0;
      m_st[1] = (m_st[1] & ~((wr_en && wr_addr == 1) ? wr_data : 8'h0)) | set_bus1;
      m_st[2] = (m_st[2] & ~((wr_en && wr_addr == 2) ? wr_data : 8'h0)) | set_host;
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("stat_bus0", stat_bus0, m_st[0]);
    chk("stat_bus1", stat_bus1, m_st[1]);
    chk("stat_host", stat_host, m_st[2]);
    for (int c = 0; c < 3; c++) begin
      chk($sformatf("sum%0d", c), lat_sum[c*SW +: SW], m_sum[c]);
      chk($sformatf("min%0d", c), lat_min[c*TW +: TW], m_min[c]);
      chk($sformatf("max%0d", c), lat_max[c*TW +: TW], m_max[c]);
      chk($sformatf("cnt%0d", c), lat_cnt[c*CW +: CW], m_cnt[c]);
    end
  endtask

  task automatic cyc(bit we, int a, int d, int s0, int s1, int sh, int st, longint jump);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = AW'(a); wr_data = DW'(d);
    set_bus0 = DW'(s0); set_bus1 = DW'(s1); set_host = DW'(sh);
    start = 3'(st);
    time_now = TW'(longint'(time_now) + 1 + jump);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R8"; idle(2);
    req = "R1"; cyc(0, 0, 0, 'hF3, 'h5A, 'hC3, 0, 0);
    cyc(1, 0, 'h81, 0, 0, 0, 0, 0); cyc(1, 1, 'h0F, 0, 0, 0, 0, 0);
    cyc(1, 2, 'hFF, 0, 0, 0, 0, 0); idle(1);
    req = "R2"; cyc(1, 0, 'hFF, 'h11, 0, 0, 0, 0); idle(1);
    req = "R3"; cyc(0, 0, 0, 'hAA, 'hAA, 'hAA, 7, 0);
    for (int a = 3; a < 16; a++) cyc(1, a, 'hFF, 0, 0, 0, 0, 0);
    idle(1);
    req = "R4"; cyc(0, 0, 0, 0, 0, 0, 1, 0); idle(5); cyc(1, 1, 'h01, 0, 0, 0, 0, 0);
    idle(1); cyc(0, 0, 0, 0, 0, 0, 1, 0); idle(2); cyc(1, 0, 'h02, 0, 0, 0, 0, 0); idle(1);
    req = "R5"; cyc(1, 0, 'h04, 0, 0, 0, 0, 7); cyc(1, 1, 'h04, 0, 0, 0, 0, 3); idle(1);
    req = "R6"; cyc(0, 0, 0, 0, 0, 0, 6, 0); idle(4); cyc(1, 2, 'h08, 0, 0, 0, 0, 0);
    cyc(1, 2, 'h08, 0, 0, 0, 0, 9); idle(1);
    req = "R10"; cyc(0, 0, 0, 0, 0, 0, 2, 0); idle(3); cyc(1, 2, 0, 0, 0, 0, 0, 0); idle(1);
    req = "R7"; cyc(0, 0, 0, 0, 0, 0, 4, 0); idle(2); cyc(1, 2, 0, 0, 0, 0, 4, 0); idle(1);
    cyc(1, 2, 0, 0, 0, 0, 0, 0); idle(1);
    req = "R9";
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 0, 0, 'hEFFF_0000);
      cyc(1, 0, 0, 0, 0, 0, 0, 0); idle(1);
    end
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 2) == 0, $urandom % 5, $urandom % 256,
          (($urandom % 4) == 0) ? $urandom % 256 : 0,
          (($urandom % 4) == 0) ? $urandom % 256 : 0,
          (($urandom % 4) == 0) ? $urandom % 256 : 0,
          (($urandom % 3) == 0) ? $urandom % 8 : 0,
          (($urandom % 50) == 0) ? longint'($urandom % 100000) : 0);
    idle(2);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule